// File: doc/BRIEF.md
# Indexed Configuration Register File

This block holds a processor's configuration and performance-control registers behind a pair of byte-wide I/O ports. Software first writes an 8-bit register index to the index port. The next access to the data port then reads or writes the register that index selects. The block holds the following registers:

- a performance-control byte;
- three configuration-control bytes;
- a fourth configuration byte that carries an I/O recovery field;
- a power/clock byte;
- a three-byte memory-region register, made of address bytes and a size code;
- two read-only identification bytes, whose values are set by parameters.

Every stored bit is also driven out on a dedicated output bus, so that the consumer logic sees the configuration directly.

A small two-state machine tracks the port protocol. In `ST_IDLE` no index is held. An index-port write (transition `T_ARM`) moves it to `ST_ARMED`. In `ST_ARMED`, a further index write (`T_REARM`) keeps the state and replaces the index. A data-port read or write (`T_CONSUME`) uses the index and returns to `ST_IDLE`. A data-port access made in `ST_IDLE` (`T_STRAY`) leaves the state unchanged and does nothing except return FFh on a read.

Several rules shape what a write actually does. Three registers are visible only while the mapping-enable bit is set. A sticky lock bit, combined with a management-mode input, freezes the bits that control management mode. One feature-enable bit exists only when the revision parameter reports stepping 1 or later.

Top module: `cfg_index_regfile`

## Requirements
- R1: Index write and data access. A write to port `IDX_PORT` (default 22h) stores the index byte. The next data-port access (port `DATA_PORT`, default 23h) acts on the selected register. Read data appears on `io_rdata` at the clock edge that samples the read strobe and holds until the next read. When `io_wr` and `io_rd` are both high, the access is a write. No register changes without a data-port write.
- R2: One access per index. Each data-port access uses up the held index. A further data-port access without a new index write is ignored: a write changes nothing and a read returns FFh.
- R3: Reset state. Reset clears every writable register to 00h, sets `io_rdata` to FFh and leaves no index held.
- R4: Unimplemented indexes. Any index not listed in R5 to R11 reads FFh and ignores writes. The listed indexes are 20h, C1h, C2h, C3h, CDh–CFh, E8h, F0h, FEh and FFh.
- R5: Mapping enable. The registers at indexes 20h (performance), E8h (config 4) and F0h (power) are visible only while config 3 (C3h) bit 4 is 1. Otherwise they read FFh, ignore writes and keep their contents.
- R6: Identification registers. Index FEh reads parameter `DEV_ID` and index FFh reads parameter `DEV_REV`. Writes to either have no effect.
- R7: Implemented and reserved bits. Each register stores only its implemented bits; all other bits read 0.
  - Performance (20h): bits 7, 2, 1, 0.
  - Config 1 (C1h): bits 3..1.
  - Config 2 (C2h): bits 7, 6, 4..1.
  - Config 3 (C3h): all 8 bits.
  - Config 4 (E8h): bits 4..0, where bits 2..0 are the I/O recovery count in bus clocks.
  - Power (F0h): bits 2..0.
- R8: Sticky lock. Config 3 bit 0 is the lock bit. Writing 1 sets it, writing 0 leaves it set, and only reset clears it.
- R9: Management-mode freeze. While the lock bit is 1 and `smm_active` is 1, writes leave config 1 bits 3..1 and config 3 bit 1 unchanged. The other config 3 bits stay writable.
- R10: Stepping-gated bit. Config 4 bit 7 is writable only when `DEV_REV[7:4]` is nonzero. Otherwise it reads 0.
- R11: Memory-region register. Indexes CDh, CEh and CFh are full 8-bit read/write registers. They appear on `region_o` as {CDh, CEh, CFh}, with CDh in the most significant byte. CFh bits 3..0 hold the size code.
- R12: Index-port reads. A read of the index port returns FFh and leaves the held index and the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_addr | input | ADDR_W | I/O port address |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Registered read data |
| smm_active | input | 1 | Processor is in management mode |
| perf_ctl_o | output | 8 | Performance control register (20h) |
| cfg1_o | output | 8 | Config 1 (C1h) |
| cfg2_o | output | 8 | Config 2 (C2h) |
| cfg3_o | output | 8 | Config 3 (C3h) |
| cfg4_o | output | 8 | Config 4 (E8h) |
| pwr_o | output | 8 | Power/clock register (F0h) |
| region_o | output | 8*REGION_BYTES | Memory-region bytes {CDh, CEh, CFh} |

## Verification
A wrong internal state in this block shows up at the ports as soon as the next read or the next output sample. The ways it can go wrong are:

- If the protocol state machine is stuck armed, a second data read returns register contents instead of FFh, one cycle after the strobe.
- If the state machine is stuck idle, every read returns FFh.
- A wrong write mask or lock decision shows up on the exported register buses at the very edge that takes the write, and again on the read-back that follows.

Sweeping every index, with mapping enabled and then disabled, exposes a decode or visibility fault at the specific index involved.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } port_state_e;

    localparam int unsigned DW = 8;

    localparam logic [DW-1:0] IX_PERF    = 8'h20;
    localparam logic [DW-1:0] IX_CFG1    = 8'hC1;
    localparam logic [DW-1:0] IX_CFG2    = 8'hC2;
    localparam logic [DW-1:0] IX_CFG3    = 8'hC3;
    localparam logic [DW-1:0] IX_REGION0 = 8'hCD;
    localparam logic [DW-1:0] IX_CFG4    = 8'hE8;
    localparam logic [DW-1:0] IX_PWR     = 8'hF0;
    localparam logic [DW-1:0] IX_ID0     = 8'hFE;
    localparam logic [DW-1:0] IX_ID1     = 8'hFF;

    localparam logic [DW-1:0] M_PERF     = 8'h87;
    localparam logic [DW-1:0] M_CFG1     = 8'h0E;
    localparam logic [DW-1:0] M_CFG2     = 8'hDE;
    localparam logic [DW-1:0] M_CFG4     = 8'h1F;
    localparam logic [DW-1:0] M_CFG4_ID  = 8'h80;
    localparam logic [DW-1:0] M_PWR      = 8'h07;

    localparam int unsigned B_LOCK   = 0;
    localparam int unsigned B_NMI    = 1;
    localparam int unsigned B_MAPEN  = 4;

    localparam logic [DW-1:0] RD_FLOAT = 8'hFF;

endpackage

// File: rtl/cfgrf_port_fsm.sv
module cfgrf_port_fsm
    import cfgrf_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] IDX_PORT  = 'h22,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DW-1:0]     io_wdata,
    output logic              acc_wr,
    output logic              acc_rd,
    output logic              float_rd,
    output logic [DW-1:0]     idx_o,
    output logic              armed_o
);

    port_state_e state_q, state_d;
    logic [DW-1:0] idx_q;

    logic rd_req, idx_wr, idx_rd, dat_wr, dat_rd, dat_any;

    assign rd_req  = io_rd & ~io_wr;
    assign idx_wr  = io_wr  && (io_addr == IDX_PORT);
    assign idx_rd  = rd_req && (io_addr == IDX_PORT);
    assign dat_wr  = io_wr  && (io_addr == DATA_PORT);
    assign dat_rd  = rd_req && (io_addr == DATA_PORT);
    assign dat_any = dat_wr | dat_rd;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (idx_wr) state_d = ST_ARMED;          // T_ARM
            end
            ST_ARMED: begin
                if (idx_wr)       state_d = ST_ARMED;    // T_REARM
                else if (dat_any) state_d = ST_IDLE;     // T_CONSUME
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (idx_wr) idx_q <= io_wdata;
        end
    end

    // outputs
    always_comb begin
        acc_wr   = 1'b0;
        acc_rd   = 1'b0;
        float_rd = idx_rd;
        unique case (state_q)
            ST_IDLE: begin
                float_rd = idx_rd | dat_rd;               // T_STRAY read
            end
            ST_ARMED: begin
                acc_wr = dat_wr;
                acc_rd = dat_rd;
            end
            default: ;
        endcase
    end

    assign idx_o   = idx_q;
    assign armed_o = (state_q == ST_ARMED);

endmodule

// File: rtl/cfgrf_regs.sv
module cfgrf_regs
    import cfgrf_pkg::*;
#(
    parameter logic [DW-1:0] DEV_REV     = 8'h13,
    parameter int unsigned REGION_BYTES  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [DW-1:0]              widx,
    input  logic [DW-1:0]              wdata,
    input  logic                       smm_active,
    output logic [DW-1:0]              perf_q,
    output logic [DW-1:0]              cfg1_q,
    output logic [DW-1:0]              cfg2_q,
    output logic [DW-1:0]              cfg3_q,
    output logic [DW-1:0]              cfg4_q,
    output logic [DW-1:0]              pwr_q,
    output logic [DW*REGION_BYTES-1:0] region_q
);

    localparam logic [DW-1:0] CFG4_WMASK =
        (DEV_REV[7:4] != 4'h0) ? (M_CFG4 | M_CFG4_ID) : M_CFG4;

    logic map_en, frozen;
    assign map_en = cfg3_q[B_MAPEN];
    assign frozen = cfg3_q[B_LOCK] & smm_active;

    logic [DW-1:0] cfg3_next;
    always_comb begin
        cfg3_next         = wdata;
        cfg3_next[B_LOCK] = cfg3_q[B_LOCK] | wdata[B_LOCK];
        if (frozen) cfg3_next[B_NMI] = cfg3_q[B_NMI];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perf_q <= '0;
            cfg1_q <= '0;
            cfg2_q <= '0;
            cfg3_q <= '0;
            cfg4_q <= '0;
            pwr_q  <= '0;
        end else if (we) begin
            unique case (widx)
                IX_CFG1: if (!frozen) cfg1_q <= wdata & M_CFG1;
                IX_CFG2: cfg2_q <= wdata & M_CFG2;
                IX_CFG3: cfg3_q <= cfg3_next;
                IX_PERF: if (map_en) perf_q <= wdata & M_PERF;
                IX_CFG4: if (map_en) cfg4_q <= wdata & CFG4_WMASK;
                IX_PWR:  if (map_en) pwr_q  <= wdata & M_PWR;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < REGION_BYTES; g++) begin : g_region
        localparam logic [DW-1:0] MY_IDX = IX_REGION0 + DW'(g);
        always_ff @(posedge clk) begin
            if (!rst_n)
                region_q[DW*(REGION_BYTES-1-g) +: DW] <= '0;
            else if (we && widx == MY_IDX)
                region_q[DW*(REGION_BYTES-1-g) +: DW] <= wdata;
        end
    end

endmodule

// File: rtl/cfgrf_rd_mux.sv
module cfgrf_rd_mux
    import cfgrf_pkg::*;
#(
    parameter logic [DW-1:0] DEV_ID      = 8'h2D,
    parameter logic [DW-1:0] DEV_REV     = 8'h13,
    parameter int unsigned REGION_BYTES  = 3
) (
    input  logic [DW-1:0]              ridx,
    input  logic [DW-1:0]              perf_q,
    input  logic [DW-1:0]              cfg1_q,
    input  logic [DW-1:0]              cfg2_q,
    input  logic [DW-1:0]              cfg3_q,
    input  logic [DW-1:0]              cfg4_q,
    input  logic [DW-1:0]              pwr_q,
    input  logic [DW*REGION_BYTES-1:0] region_q,
    output logic [DW-1:0]              rval
);

    logic map_en;
    assign map_en = cfg3_q[B_MAPEN];

    always_comb begin
        rval = RD_FLOAT;
        unique case (ridx)
            IX_CFG1: rval = cfg1_q;
            IX_CFG2: rval = cfg2_q;
            IX_CFG3: rval = cfg3_q;
            IX_ID0:  rval = DEV_ID;
            IX_ID1:  rval = DEV_REV;
            IX_PERF: if (map_en) rval = perf_q;
            IX_CFG4: if (map_en) rval = cfg4_q;
            IX_PWR:  if (map_en) rval = pwr_q;
            default: ;
        endcase
        for (int g = 0; g < REGION_BYTES; g++) begin
            if (ridx == IX_REGION0 + DW'(g))
                rval = region_q[DW*(REGION_BYTES-1-g) +: DW];
        end
    end

endmodule

// File: rtl/cfg_index_regfile.sv
module cfg_index_regfile
    import cfgrf_pkg::*;
#(
    parameter int unsigned ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] IDX_PORT  = 'h22,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h23,
    parameter logic [7:0] DEV_ID         = 8'h2D,
    parameter logic [7:0] DEV_REV        = 8'h13,
    parameter int unsigned REGION_BYTES  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      io_wr,
    input  logic                      io_rd,
    input  logic [ADDR_W-1:0]         io_addr,
    input  logic [7:0]                io_wdata,
    output logic [7:0]                io_rdata,
    input  logic                      smm_active,
    output logic [7:0]                perf_ctl_o,
    output logic [7:0]                cfg1_o,
    output logic [7:0]                cfg2_o,
    output logic [7:0]                cfg3_o,
    output logic [7:0]                cfg4_o,
    output logic [7:0]                pwr_o,
    output logic [8*REGION_BYTES-1:0] region_o
);

    logic          acc_wr, acc_rd, float_rd, armed;
    logic [DW-1:0] idx, rval;

    cfgrf_port_fsm #(
        .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata),
        .acc_wr(acc_wr), .acc_rd(acc_rd), .float_rd(float_rd),
        .idx_o(idx), .armed_o(armed)
    );

    cfgrf_regs #(
        .DEV_REV(DEV_REV), .REGION_BYTES(REGION_BYTES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(acc_wr), .widx(idx), .wdata(io_wdata),
        .smm_active(smm_active),
        .perf_q(perf_ctl_o), .cfg1_q(cfg1_o), .cfg2_q(cfg2_o), .cfg3_q(cfg3_o),
        .cfg4_q(cfg4_o), .pwr_q(pwr_o), .region_q(region_o)
    );

    cfgrf_rd_mux #(
        .DEV_ID(DEV_ID), .DEV_REV(DEV_REV), .REGION_BYTES(REGION_BYTES)
    ) u_mux (
        .ridx(idx), .perf_q(perf_ctl_o), .cfg1_q(cfg1_o), .cfg2_q(cfg2_o),
        .cfg3_q(cfg3_o), .cfg4_q(cfg4_o), .pwr_q(pwr_o), .region_q(region_o),
        .rval(rval)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        io_rdata <= RD_FLOAT;
        else if (acc_rd)   io_rdata <= rval;
        else if (float_rd) io_rdata <= RD_FLOAT;
    end

endmodule

// File: rtl/cfg_index_regfile_chk.sv
module cfg_index_regfile_chk #(
    parameter int unsigned ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h23,
    parameter logic [7:0] DEV_REV        = 8'h13,
    parameter int unsigned REGION_BYTES  = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      io_wr,
    input logic                      io_rd,
    input logic [ADDR_W-1:0]         io_addr,
    input logic [7:0]                io_rdata,
    input logic                      smm_active,
    input logic                      armed,
    input logic [7:0]                perf_ctl_o,
    input logic [7:0]                cfg1_o,
    input logic [7:0]                cfg2_o,
    input logic [7:0]                cfg3_o,
    input logic [7:0]                cfg4_o,
    input logic [7:0]                pwr_o,
    input logic [8*REGION_BYTES-1:0] region_o
);

    p_no_data_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == DATA_PORT) |=>
            ($stable(cfg1_o) && $stable(cfg2_o) && $stable(region_o)));

    p_stray_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && io_addr == DATA_PORT && !armed) |=> io_rdata == 8'hFF);

    p_hidden_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg3_o[4] |=> ($stable(perf_ctl_o) && $stable(cfg4_o) && $stable(pwr_o)));

    p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((perf_ctl_o & 8'h78) == 8'h00) && ((cfg1_o & 8'hF1) == 8'h00) &&
        ((cfg2_o & 8'h21) == 8'h00) && ((pwr_o & 8'hF8) == 8'h00) &&
        ((cfg4_o & 8'h60) == 8'h00));

    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg3_o[0] |=> cfg3_o[0]);

    p_smm_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg3_o[0] && smm_active) |=> ($stable(cfg1_o) && $stable(cfg3_o[1])));

    p_step_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg4_o[7] |-> (DEV_REV[7:4] != 4'h0));

endmodule

bind cfg_index_regfile cfg_index_regfile_chk #(
    .ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .DEV_REV(DEV_REV),
    .REGION_BYTES(REGION_BYTES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_rdata(io_rdata), .smm_active(smm_active), .armed(armed),
    .perf_ctl_o(perf_ctl_o), .cfg1_o(cfg1_o), .cfg2_o(cfg2_o), .cfg3_o(cfg3_o),
    .cfg4_o(cfg4_o), .pwr_o(pwr_o), .region_o(region_o)
);

// File: tb/cfg_index_regfile_tb_top.sv
module cfg_index_regfile_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] P_IDX = 16'h22;
    localparam logic [15:0] P_DAT = 16'h23;
    localparam logic [7:0] ID0 = 8'h2D;
    localparam logic [7:0] ID1 = 8'h13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic io_wr = 1'b0, io_rd = 1'b0, smm_active = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0] io_wdata = '0;

    logic [7:0] io_rdata, perf_ctl_o, cfg1_o, cfg2_o, cfg3_o, cfg4_o, pwr_o;
    logic [23:0] region_o;
    logic [7:0] e_rdata, e_perf, e_cfg1, e_cfg2, e_cfg3, e_cfg4, e_pwr;
    logic [23:0] e_region;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_index_regfile #(.DEV_ID(ID0), .DEV_REV(ID1)) dut_i (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .smm_active(smm_active),
        .perf_ctl_o(perf_ctl_o), .cfg1_o(cfg1_o), .cfg2_o(cfg2_o), .cfg3_o(cfg3_o),
        .cfg4_o(cfg4_o), .pwr_o(pwr_o), .region_o(region_o));

    // early stepping variant: revision upper nibble 0
    cfg_index_regfile #(.DEV_ID(8'h29), .DEV_REV(8'h05)) dut_early_i (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(e_rdata), .smm_active(smm_active),
        .perf_ctl_o(e_perf), .cfg1_o(e_cfg1), .cfg2_o(e_cfg2), .cfg3_o(e_cfg3),
        .cfg4_o(e_cfg4), .pwr_o(e_pwr), .region_o(e_region));

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] model [256];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit visible(int i, bit mapen);
        case (i)
            'h20, 'hE8, 'hF0: return mapen;
            'hC1, 'hC2, 'hC3, 'hCD, 'hCE, 'hCF, 'hFE, 'hFF: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] wmask(int i);
        case (i)
            'h20: return 8'h87;
            'hC1: return 8'h0E;
            'hC2: return 8'hDE;
            'hCD, 'hCE, 'hCF: return 8'hFF;
            'hE8: return 8'h9F;
            'hF0: return 8'h07;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(int i, bit mapen);
        if (!visible(i, mapen)) return (i == 'h20 || i == 'hE8 || i == 'hF0) ? "R5" : "R4";
        if (i >= 'hFE) return "R6";
        if (i >= 'hCD && i <= 'hCF) return "R11";
        return "R7";
    endfunction

    task automatic cyc_end();
        @(posedge clk);
        @(negedge clk);
        io_wr = 1'b0;
        io_rd = 1'b0;
    endtask

    task automatic idx_wr(logic [7:0] v);
        io_addr = P_IDX; io_wdata = v; io_wr = 1'b1;
        cyc_end();
    endtask

    task automatic dat_wr(logic [7:0] v);
        io_addr = P_DAT; io_wdata = v; io_wr = 1'b1;
        cyc_end();
    endtask

    task automatic port_rd(logic [15:0] a, output logic [7:0] v);
        io_addr = a; io_rd = 1'b1;
        cyc_end();
        v = io_rdata;
    endtask

    task automatic sweep(bit mapen, int mul, int add);
        logic [7:0] r;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] d;
            if (i == 'hC3) continue;
            d = 8'(i * mul + add);
            idx_wr(8'(i));
            dat_wr(d);
            if (visible(i, mapen))
                model[i] = (model[i] & ~wmask(i)) | (d & wmask(i));
            idx_wr(8'(i));
            port_rd(P_DAT, r);
            check(tag_of(i, mapen), r, visible(i, mapen) ? model[i] : 8'hFF);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        model['hFE] = ID0;
        model['hFF] = ID1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset state
        check("R3 regs", {cfg1_o, cfg2_o, cfg3_o, perf_ctl_o}, 32'h0);
        check("R3 regs2", {cfg4_o, pwr_o, region_o[15:0]}, 32'h0);
        check("R3 rdata", io_rdata, 8'hFF);
        port_rd(P_DAT, r);
        check("R3 no index held", r, 8'hFF);

        // R6 / R1 basic read
        idx_wr(8'hFE); port_rd(P_DAT, r); check("R6 id0", r, ID0);
        idx_wr(8'hFF); port_rd(P_DAT, r); check("R6 id1", r, ID1);

        // enable mapping
        idx_wr(8'hC3); dat_wr(8'h10); model['hC3] = 8'h10;
        check("R1 cfg3 out", cfg3_o, 8'h10);

        sweep(1'b1, 37, 5);
        check("R7 cfg1 bus", cfg1_o, model['hC1]);
        check("R7 cfg2 bus", cfg2_o, model['hC2]);
        check("R7 perf bus", perf_ctl_o, model['h20]);
        check("R7 pwr bus", pwr_o, model['hF0]);
        check("R11 region bus", region_o, {model['hCD], model['hCE], model['hCF]});
        check("R10 early cfg4", e_cfg4, model['hE8] & 8'h1F);

        // R10: explicit all-ones write
        idx_wr(8'hE8); dat_wr(8'hFF); model['hE8] = 8'h9F;
        check("R10 cfg4 stepping1", cfg4_o, 8'h9F);
        check("R10 cfg4 early", e_cfg4, 8'h1F);

        // R2: index consumed
        idx_wr(8'hC1); port_rd(P_DAT, r); check("R2 first read", r, model['hC1]);
        port_rd(P_DAT, r); check("R2 second read", r, 8'hFF);
        dat_wr(8'h00); check("R2 stray write", cfg1_o, model['hC1]);
        // R12: index-port read keeps index
        idx_wr(8'hCE); port_rd(P_IDX, r); check("R12 index read", r, 8'hFF);
        port_rd(P_DAT, r); check("R12 index kept", r, model['hCE]);
        // R1: simultaneous strobes act as write
        idx_wr(8'hCD);
        io_addr = P_DAT; io_wdata = 8'h5A; io_wr = 1'b1; io_rd = 1'b1; cyc_end();
        model['hCD] = 8'h5A;
        check("R1 wr wins", region_o[23:16], 8'h5A);

        // mapping disabled sweep
        idx_wr(8'hC3); dat_wr(8'h00); model['hC3] = 8'h00;
        sweep(1'b0, 53, 11);
        idx_wr(8'hC3); dat_wr(8'h10); model['hC3] = 8'h10;
        idx_wr(8'h20); port_rd(P_DAT, r); check("R5 perf kept", r, model['h20]);
        idx_wr(8'hE8); port_rd(P_DAT, r); check("R5 cfg4 kept", r, model['hE8]);
        idx_wr(8'hF0); port_rd(P_DAT, r); check("R5 pwr kept", r, model['hF0]);

        // R8 / R9: lock and management mode
        idx_wr(8'hC3); dat_wr(8'h11);
        idx_wr(8'hC1); dat_wr(8'h0E); check("R9 unlocked outside smm", cfg1_o, 8'h0E);
        smm_active = 1'b1;
        idx_wr(8'hC1); dat_wr(8'h00); check("R9 cfg1 frozen", cfg1_o, 8'h0E);
        idx_wr(8'hC3); dat_wr(8'h12); check("R9 r8 cfg3 in smm", cfg3_o, 8'h11);
        idx_wr(8'hC3); dat_wr(8'h50); check("R9 other bits free", cfg3_o, 8'h51);
        smm_active = 1'b0;
        idx_wr(8'hC3); dat_wr(8'h12); check("R8 lock sticky", cfg3_o, 8'h13);
        idx_wr(8'hC1); dat_wr(8'h04); check("R9 released", cfg1_o, 8'h04);

        // R3: reset clears lock
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        check("R3 R8 reset clears", {cfg3_o, cfg1_o, io_rdata}, {8'h00, 8'h00, 8'hFF});

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule